// File: doc/BRIEF.md
# Partitioned Condition Register File

This block holds the condition state of a processor core as eight separately addressed 4-bit fields rather than as one flag register. Each kind of flag producer has its own write port, and every flag write replaces one whole field. Flag-setting integer results always land in field 0. Floating-point flag results always land in field 1. Compare results go to whichever field the instruction names. Because a field is only ever written whole, a later renaming stage can treat each field as an independent register.

A condition-logic port takes two single bits, each from any field, and combines them with one of eight boolean operations. It writes the result to one bit anywhere in the register. Two combinational read ports let a branch unit test any bit. A 32-bit view with a per-field write mask serves move-to and move-from transfers.

A field keeps its contents until some port explicitly writes it. Nothing shifts or queues between fields.

Top module: `cond_field_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 bits of `cr_view` to zero.
- R2: With `int_we` high, field 0 takes `int_flags` at the next edge and no other field changes. With `int_we` low, `int_flags` has no effect.
- R3: With `fp_we` high, field 1 takes `fp_flags` at the next edge and no other field changes.
- R4: A compare write fills field `cmp_sel` as follows: bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO. `cmp_rel` 2'b01 sets only LT, 2'b10 sets only GT, and 2'b00 or 2'b11 sets only EQ. SO copies `cmp_so`.
- R5: A condition-logic write computes op(A,B) and writes it to view bit `cl_dst`. A is view bit `cl_src_a` and B is view bit `cl_src_b`. The `cl_op` codes are: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV (XNOR), 6 ANDC (A & ~B), 7 ORC (A | ~B).
- R6: A condition-logic write changes only the addressed bit. Its operands are the values held before that edge.
- R7: When ports target the same field in one cycle, the field is written by the highest-priority port only. The order is move-to, then condition-logic, then compare, then floating-point, then integer. Writes to different fields in one cycle all take effect.
- R8: A field that no port writes in a cycle keeps its value.
- R9: With `mt_we` high, each field k whose `mt_mask[k]` is set takes `mt_data[4k+3:4k]`. Field k always appears at `cr_view[4k+3:4k]`.
- R10: `br0_bit` and `br1_bit` equal view bits `br0_sel` and `br1_sel` combinationally. A written value becomes visible only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_we | input | 1 | Integer flag-setting write enable |
| int_flags | input | 4 | Integer flag field value |
| fp_we | input | 1 | Floating-point flag write enable |
| fp_flags | input | 4 | Floating-point flag field value |
| cmp_we | input | 1 | Compare result write enable |
| cmp_sel | input | 3 | Target field of the compare |
| cmp_rel | input | 2 | Compare relation code |
| cmp_so | input | 1 | Summary-overflow bit carried with the compare |
| cl_we | input | 1 | Condition-logic write enable |
| cl_op | input | 3 | Boolean operation code |
| cl_src_a | input | 5 | Bit address of operand A |
| cl_src_b | input | 5 | Bit address of operand B |
| cl_dst | input | 5 | Bit address of the result |
| br0_sel | input | 5 | Bit address for branch read 0 |
| br0_bit | output | 1 | Branch read 0 value |
| br1_sel | input | 5 | Bit address for branch read 1 |
| br1_bit | output | 1 | Branch read 1 value |
| mt_we | input | 1 | Move-to write enable |
| mt_mask | input | 8 | Per-field move-to mask |
| mt_data | input | 32 | Move-to value |
| cr_view | output | 32 | Whole register, move-from view |

## Verification
The integer and floating-point ports are swept over all 16 values. Comparisons cover every field, relation code and SO value. These sweeps separate a correct target field from a neighbour and show whether SO is copied or the relation is encoded. The condition-logic port runs all eight operations over 256 operand and destination triples on a preloaded mixed pattern, which exposes a swapped operation, a misread operand or a spill onto sibling bits. All 32 subsets of simultaneous ports aimed at one field test the priority order. All 256 move-to masks and a full sweep of both branch selectors test field placement.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam int FLAG_W = 4;

  typedef enum logic [2:0] {
    CL_AND  = 3'd0,
    CL_OR   = 3'd1,
    CL_XOR  = 3'd2,
    CL_NAND = 3'd3,
    CL_NOR  = 3'd4,
    CL_EQV  = 3'd5,
    CL_ANDC = 3'd6,
    CL_ORC  = 3'd7
  } cl_op_e;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_MT   = 3'd1,
    WIN_CL   = 3'd2,
    WIN_CMP  = 3'd3,
    WIN_FP   = 3'd4,
    WIN_INT  = 3'd5
  } win_e;

  // Boolean combination of two condition bits.
  function automatic logic cl_eval(cl_op_e op, logic a, logic b);
    logic r;
    case (op)
      CL_AND:  r = a & b;
      CL_OR:   r = a | b;
      CL_XOR:  r = a ^ b;
      CL_NAND: r = ~(a & b);
      CL_NOR:  r = ~(a | b);
      CL_EQV:  r = ~(a ^ b);
      CL_ANDC: r = a & ~b;
      default: r = a | ~b;
    endcase
    return r;
  endfunction

  // Field value of a compare: {LT, GT, EQ, SO}.
  function automatic logic [FLAG_W-1:0] cmp_encode(rel_e rel, logic so);
    logic [FLAG_W-1:0] f;
    case (rel)
      REL_LT:  f = {1'b1, 1'b0, 1'b0, so};
      REL_GT:  f = {1'b0, 1'b1, 1'b0, so};
      default: f = {1'b0, 1'b0, 1'b1, so};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cfr_bit_read.sv
module cfr_bit_read #(
  parameter int VIEW_W = 32,
  localparam int BSEL_W = $clog2(VIEW_W)
) (
  input  logic [VIEW_W-1:0] view,
  input  logic [BSEL_W-1:0] sel,
  output logic              bit_o
);
  assign bit_o = view[sel];
endmodule

// File: rtl/cfr_logic_unit.sv
module cfr_logic_unit
  import cfr_pkg::*;
#(
  parameter int VIEW_W = 32,
  localparam int BSEL_W = $clog2(VIEW_W)
) (
  input  logic [VIEW_W-1:0] view,
  input  cl_op_e            op,
  input  logic [BSEL_W-1:0] src_a,
  input  logic [BSEL_W-1:0] src_b,
  output logic              opnd_a,
  output logic              opnd_b,
  output logic              result
);
  cfr_bit_read #(.VIEW_W(VIEW_W)) u_rd_a (.view(view), .sel(src_a), .bit_o(opnd_a));
  cfr_bit_read #(.VIEW_W(VIEW_W)) u_rd_b (.view(view), .sel(src_b), .bit_o(opnd_b));

  assign result = cl_eval(op, opnd_a, opnd_b);
endmodule

// File: rtl/cfr_field_slice.sv
module cfr_field_slice
  import cfr_pkg::*;
#(
  parameter int W = FLAG_W,
  localparam int POS_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mt_hit,
  input  logic [W-1:0]     mt_val,
  input  logic             cl_hit,
  input  logic [POS_W-1:0] cl_pos,
  input  logic             cl_val,
  input  logic             cmp_hit,
  input  logic [W-1:0]     cmp_val,
  input  logic             fp_hit,
  input  logic [W-1:0]     fp_val,
  input  logic             int_hit,
  input  logic [W-1:0]     int_val,
  output logic [W-1:0]     q,
  output win_e             win
);
  logic [W-1:0] d;

  always_comb begin
    win = WIN_NONE;
    d   = q;
    if (mt_hit) begin
      win = WIN_MT;
      d   = mt_val;
    end else if (cl_hit) begin
      win       = WIN_CL;
      d[cl_pos] = cl_val;
    end else if (cmp_hit) begin
      win = WIN_CMP;
      d   = cmp_val;
    end else if (fp_hit) begin
      win = WIN_FP;
      d   = fp_val;
    end else if (int_hit) begin
      win = WIN_INT;
      d   = int_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cond_field_regfile.sv
module cond_field_regfile
  import cfr_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int INT_FIELD  = 0,
  parameter int FP_FIELD   = 1,
  localparam int VIEW_W = NUM_FIELDS * FLAG_W,
  localparam int FSEL_W = $clog2(NUM_FIELDS),
  localparam int BSEL_W = $clog2(VIEW_W),
  localparam int POS_W  = $clog2(FLAG_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  int_we,
  input  logic [FLAG_W-1:0]     int_flags,
  input  logic                  fp_we,
  input  logic [FLAG_W-1:0]     fp_flags,
  input  logic                  cmp_we,
  input  logic [FSEL_W-1:0]     cmp_sel,
  input  logic [1:0]            cmp_rel,
  input  logic                  cmp_so,
  input  logic                  cl_we,
  input  logic [2:0]            cl_op,
  input  logic [BSEL_W-1:0]     cl_src_a,
  input  logic [BSEL_W-1:0]     cl_src_b,
  input  logic [BSEL_W-1:0]     cl_dst,
  input  logic [BSEL_W-1:0]     br0_sel,
  output logic                  br0_bit,
  input  logic [BSEL_W-1:0]     br1_sel,
  output logic                  br1_bit,
  input  logic                  mt_we,
  input  logic [NUM_FIELDS-1:0] mt_mask,
  input  logic [VIEW_W-1:0]     mt_data,
  output logic [VIEW_W-1:0]     cr_view
);
  // Named internal events for the checker
  logic                  cl_result;
  logic                  cl_opnd_a;
  logic                  cl_opnd_b;
  logic [FLAG_W-1:0]     cmp_field_val;
  logic [FSEL_W-1:0]     cl_dst_field;
  logic [POS_W-1:0]      cl_dst_pos;
  logic [NUM_FIELDS-1:0] field_written;
  win_e                  field_win [NUM_FIELDS];

  assign cl_dst_field  = cl_dst[BSEL_W-1:POS_W];
  assign cl_dst_pos    = cl_dst[POS_W-1:0];
  assign cmp_field_val = cmp_encode(rel_e'(cmp_rel), cmp_so);

  cfr_logic_unit #(.VIEW_W(VIEW_W)) u_logic (
    .view  (cr_view),
    .op    (cl_op_e'(cl_op)),
    .src_a (cl_src_a),
    .src_b (cl_src_b),
    .opnd_a(cl_opnd_a),
    .opnd_b(cl_opnd_b),
    .result(cl_result)
  );

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    logic mt_hit_k, cl_hit_k, cmp_hit_k, fp_hit_k, int_hit_k;

    assign mt_hit_k  = mt_we && mt_mask[k];
    assign cl_hit_k  = cl_we && (cl_dst_field == FSEL_W'(k));
    assign cmp_hit_k = cmp_we && (cmp_sel == FSEL_W'(k));
    assign fp_hit_k  = fp_we && (k == FP_FIELD);
    assign int_hit_k = int_we && (k == INT_FIELD);

    cfr_field_slice #(.W(FLAG_W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .mt_hit (mt_hit_k),
      .mt_val (mt_data[k*FLAG_W +: FLAG_W]),
      .cl_hit (cl_hit_k),
      .cl_pos (cl_dst_pos),
      .cl_val (cl_result),
      .cmp_hit(cmp_hit_k),
      .cmp_val(cmp_field_val),
      .fp_hit (fp_hit_k),
      .fp_val (fp_flags),
      .int_hit(int_hit_k),
      .int_val(int_flags),
      .q      (cr_view[k*FLAG_W +: FLAG_W]),
      .win    (field_win[k])
    );

    assign field_written[k] = (field_win[k] != WIN_NONE);
  end

  cfr_bit_read #(.VIEW_W(VIEW_W)) u_br0 (.view(cr_view), .sel(br0_sel), .bit_o(br0_bit));
  cfr_bit_read #(.VIEW_W(VIEW_W)) u_br1 (.view(cr_view), .sel(br1_sel), .bit_o(br1_bit));

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int NUM_FIELDS = 8,
  parameter int INT_FIELD  = 0,
  parameter int FP_FIELD   = 1,
  localparam int FW     = 4,
  localparam int VIEW_W = NUM_FIELDS * FW,
  localparam int FSEL_W = $clog2(NUM_FIELDS),
  localparam int BSEL_W = $clog2(VIEW_W)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  int_we,
  input logic [FW-1:0]         int_flags,
  input logic                  fp_we,
  input logic [FW-1:0]         fp_flags,
  input logic                  cmp_we,
  input logic [FSEL_W-1:0]     cmp_sel,
  input logic                  cmp_so,
  input logic                  cl_we,
  input logic [BSEL_W-1:0]     cl_dst,
  input logic                  mt_we,
  input logic [NUM_FIELDS-1:0] mt_mask,
  input logic [VIEW_W-1:0]     mt_data,
  input logic [VIEW_W-1:0]     cr_view,
  input logic [NUM_FIELDS-1:0] field_written
);
  logic [VIEW_W-1:0] mt_bits;
  logic [VIEW_W-1:0] int_keep;
  logic [VIEW_W-1:0] fp_keep;

  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++) mt_bits[k*FW +: FW] = {FW{mt_mask[k]}};
  end
  assign int_keep = ~({{(VIEW_W-FW){1'b0}}, {FW{1'b1}}} << (INT_FIELD*FW));
  assign fp_keep  = ~({{(VIEW_W-FW){1'b0}}, {FW{1'b1}}} << (FP_FIELD*FW));

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> cr_view == '0); // R1

  AST_INT_FIELD_ONLY: assert property (@(posedge clk) disable iff (rst)
    (int_we && !fp_we && !cmp_we && !cl_we && !mt_we) |=>
      (cr_view[INT_FIELD*FW +: FW] == $past(int_flags)) &&
      (((cr_view ^ $past(cr_view)) & int_keep) == '0)); // R2

  AST_FP_FIELD_ONLY: assert property (@(posedge clk) disable iff (rst)
    (fp_we && !int_we && !cmp_we && !cl_we && !mt_we) |=>
      (cr_view[FP_FIELD*FW +: FW] == $past(fp_flags)) &&
      (((cr_view ^ $past(cr_view)) & fp_keep) == '0)); // R3

  AST_CMP_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !cl_we && !mt_we) |=>
      ($countones(FW'(cr_view >> ($past(cmp_sel) * FW)) & 4'b1110) == 1) &&
      (cr_view[$past(cmp_sel) * FW] == $past(cmp_so))); // R4

  AST_CL_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (cl_we && !int_we && !fp_we && !cmp_we && !mt_we) |=>
      (((cr_view ^ $past(cr_view)) & ~(VIEW_W'(1) << $past(cl_dst))) == '0)); // R6

  AST_MT_MASKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    mt_we |=> (((cr_view ^ $past(mt_data)) & $past(mt_bits)) == '0)); // R9

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_hold
    AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !field_written[k] |=> $stable(cr_view[k*FW +: FW])); // R8
  end

endmodule

bind cond_field_regfile cfr_checker #(
  .NUM_FIELDS(NUM_FIELDS),
  .INT_FIELD (INT_FIELD),
  .FP_FIELD  (FP_FIELD)
) u_cfr_checker (.*);

// File: tb/test_cond_field_regfile.sv
`timescale 1ns/1ps
module test_cond_field_regfile;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        int_we, fp_we, cmp_we, cl_we, mt_we, cmp_so;
  logic [3:0]  int_flags, fp_flags;
  logic [2:0]  cmp_sel, cl_op;
  logic [1:0]  cmp_rel;
  logic [4:0]  cl_src_a, cl_src_b, cl_dst, br0_sel, br1_sel;
  logic [7:0]  mt_mask;
  logic [31:0] mt_data, cr_view;
  logic        br0_bit, br1_bit;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model;

  always #(CLK_NS/2) clk = ~clk;

  cond_field_regfile i_cond_field_regfile (
    .clk, .rst, .int_we, .int_flags, .fp_we, .fp_flags, .cmp_we, .cmp_sel,
    .cmp_rel, .cmp_so, .cl_we, .cl_op, .cl_src_a, .cl_src_b, .cl_dst,
    .br0_sel, .br0_bit, .br1_sel, .br1_bit, .mt_we, .mt_mask, .mt_data, .cr_view
  );

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    int_we = 0; fp_we = 0; cmp_we = 0; cl_we = 0; mt_we = 0;
  endtask

  // Requirement-level model of the boolean codes (R5)
  function automatic logic op_ref(logic [2:0] op, logic a, logic b);
    logic [3:0] tt;
    // truth table indexed by {a,b}
    case (op)
      3'd0: tt = 4'b1000;
      3'd1: tt = 4'b1110;
      3'd2: tt = 4'b0110;
      3'd3: tt = 4'b0111;
      3'd4: tt = 4'b0001;
      3'd5: tt = 4'b1001;
      3'd6: tt = 4'b0100;
      default: tt = 4'b1101;
    endcase
    return tt[{a, b}];
  endfunction

  // R4 field value from the relation code
  function automatic logic [3:0] cmp_ref(logic [1:0] rel, logic so);
    int idx = (rel == 2'b01) ? 0 : (rel == 2'b10) ? 1 : 2;
    return (4'b1000 >> idx) | {3'b000, so};
  endfunction

  // R7 priority applied field by field
  function automatic logic [31:0] next_ref(logic [31:0] cur);
    logic [31:0] n = cur;
    for (int f = 0; f < 8; f++) begin
      if (mt_we && mt_mask[f])                  n[f*4 +: 4] = mt_data[f*4 +: 4];
      else if (cl_we && (int'(cl_dst) / 4 == f)) n[cl_dst] = op_ref(cl_op, cur[cl_src_a], cur[cl_src_b]);
      else if (cmp_we && (int'(cmp_sel) == f))   n[f*4 +: 4] = cmp_ref(cmp_rel, cmp_so);
      else if (fp_we && f == 1)                  n[f*4 +: 4] = fp_flags;
      else if (int_we && f == 0)                 n[f*4 +: 4] = int_flags;
    end
    return n;
  endfunction

  task automatic step(input string req);
    logic [31:0] exp = next_ref(model);
    #1;
    compare(cr_view, model, "R10 before edge");
    @(posedge clk); #1;
    model = exp;
    compare(cr_view, exp, req);
    idle();
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    int_flags = 0; fp_flags = 0; cmp_sel = 0; cmp_rel = 0; cmp_so = 0;
    cl_op = 0; cl_src_a = 0; cl_src_b = 0; cl_dst = 0;
    br0_sel = 0; br1_sel = 0; mt_mask = 0; mt_data = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0; model = 0;
    compare(cr_view, 32'h0, "R1 reset state");

    // R2: every integer flag value, then ignored without enable
    for (int v = 0; v < 16; v++) begin
      int_we = 1; int_flags = 4'(v); step("R2 integer write");
    end
    for (int v = 0; v < 4; v++) begin
      int_flags = 4'(v * 5); step("R2 no enable ignored");
    end

    // R3: every floating-point value
    for (int v = 0; v < 16; v++) begin
      fp_we = 1; fp_flags = 4'(15 - v); step("R3 float write");
    end

    // R4: every field, relation and SO
    for (int s = 0; s < 8; s++)
      for (int r = 0; r < 4; r++)
        for (int o = 0; o < 2; o++) begin
          cmp_we = 1; cmp_sel = 3'(s); cmp_rel = 2'(r); cmp_so = 1'(o);
          step("R4 compare encode");
        end

    // R9: every move-to mask
    for (int m = 0; m < 256; m++) begin
      mt_we = 1; mt_mask = 8'(m); mt_data = 32'h9E3779B9 * (m + 1);
      step("R9 masked move-to");
    end

    // R5/R6: all operations on a mixed preload
    mt_we = 1; mt_mask = 8'hFF; mt_data = 32'hA5C3961E; step("R9 preload");
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 32; a++) begin
        cl_we = 1; cl_op = 3'(op); cl_src_a = 5'(a);
        cl_src_b = 5'((a * 7 + 3) % 32); cl_dst = 5'((a * 5 + op + 1) % 32);
        step("R5 R6 condition logic");
      end

    // R7: every subset of ports aimed at one field
    for (int tgt = 0; tgt < 2; tgt++)
      for (int m = 0; m < 32; m++) begin
        mt_we = m[0]; mt_mask = 8'(1 << tgt) | 8'h80; mt_data = 32'h3C5A_0F69 ^ (m * 32'h01010101);
        cl_we = m[1]; cl_op = 3'd2; cl_src_a = 5'(m); cl_src_b = 5'(31 - m); cl_dst = 5'(tgt * 4 + m % 4);
        cmp_we = m[2]; cmp_sel = 3'(tgt); cmp_rel = 2'(m % 3); cmp_so = m[3];
        fp_we = m[3]; fp_flags = 4'(m + 3);
        int_we = m[4]; int_flags = 4'(m + 9);
        step("R7 priority");
      end

    // R8: idle cycles leave everything
    for (int i = 0; i < 3; i++) step("R8 hold");

    // R10: both branch reads over every bit
    for (int s = 0; s < 32; s++) begin
      br0_sel = 5'(s); br1_sel = 5'(31 - s);
      #2;
      compare({31'b0, br0_bit}, {31'b0, model[s]}, "R10 branch read 0");
      compare({31'b0, br1_bit}, {31'b0, model[31 - s]}, "R10 branch read 1");
    end

    // R1: reset from a nonzero state
    mt_we = 1; mt_mask = 8'hFF; mt_data = 32'hFFFF_FFFF; step("R9 fill");
    rst = 1; @(posedge clk); #1; rst = 0; model = 0;
    compare(cr_view, 32'h0, "R1 reset clears");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule